// File: doc/BRIEF.md
# Serial ADC Host Controller with Power-Down Handling

This block sits on the host side of a three-wire link to a 12-bit single-channel successive-approximation converter. It divides the system clock down to a serial clock and frames every transfer with an active-low chip select. It samples the converter's data line on each serial-clock falling edge and delivers the 12-bit result with a one-cycle valid strobe.

The converter's power state is not set by a register. It follows from where chip select rises inside a frame. A frame that ends early, between the 10th and 15th falling edge, puts the converter to sleep. A full 16-clock frame keeps it running or wakes it. The first result after any wake-up is garbage. The controller therefore tracks the power state, runs a discarded dummy frame after reset and after every wake, and turns a conversion request made while asleep into a dummy frame followed by a real one. Commands arrive over a valid/ready handshake. A chip-select-high quiet gap follows every frame, so back-to-back frames take 20 serial-clock periods.

Top module: `adc_sleep_host`

## Requirements
- R1: During reset `adc_cs_n` and `adc_sclk` are 1, `result_valid` is 0 and `pwr_state` is 0 (unknown). After reset the block is busy and runs one full dummy frame with no `result_valid`. Then `pwr_state` becomes 1 (normal) and never returns to 0.
- R2: `adc_sclk` is high whenever `adc_cs_n` is high. Inside a frame each SCLK half period lasts DIV system clocks.
- R3: A conversion frame has exactly FRAME_BITS (16) falling SCLK edges. The data line is sampled just before each falling edge. The first 4 samples are dropped and the last 12 form `result`, first sample as MSB.
- R4: `result_valid` is a one-cycle pulse in the cycle `adc_cs_n` rises at the end of a conversion frame. It is asserted only with `pwr_state` = 1 and never for dummy or sleep frames.
- R5: `cmd_op` = 2'b01 (sleep) in normal state runs a frame in which chip select rises after falling edge SLEEP_EDGE (10 to 14) and before the next one. `pwr_state` then becomes 2 (shutdown), with no `result_valid`.
- R6: `cmd_op` = 2'b10 (wake) in shutdown runs one full 16-edge dummy frame with no `result_valid`. `pwr_state` then becomes 1.
- R7: `cmd_op` = 2'b00 (convert) in shutdown runs a dummy frame and then a conversion frame. Exactly one `result_valid` follows, carrying the second frame's data.
- R8: After every frame `adc_cs_n` stays high for at least (2*QUIET_CLKS-1)*DIV system clocks before the next frame starts.
- R9: A command is consumed when `cmd_valid` and `cmd_ready` are both 1. Sleep in shutdown, wake in normal and `cmd_op` = 2'b11 start no frame and change no state.
- R10: `busy` is 1 and `cmd_ready` is 0 during a frame, its quiet gap and any pending dummy or chained frame. A command held during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 convert, 01 sleep, 10 wake, 11 no-op |
| cmd_ready | output | 1 | Command is consumed this cycle if valid |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdata | input | 1 | Serial data from converter |
| result | output | 12 | Last valid conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| pwr_state | output | 2 | 0 unknown, 1 normal, 2 shutdown |
| busy | output | 1 | Frame, gap or pending frame in progress |

## Verification
The bench pairs the controller with a behavioural converter. The model decides its own power state from how many falling edges each frame held, and it drives a frame-indexed pattern only when it was powered at frame start. Otherwise it drives all ones. Conversions in steady normal state separate correct bit order and dropping of the leading bits from shifted or reversed capture. A sleep followed by a convert shows whether exactly one result is thrown away: if the dummy frame is kept, the all-ones word appears; if one frame too many is dropped, no result appears. Repeated sleep or wake requests, no-op codes and commands held while busy must leave both the frame count and the power state unchanged.

// File: rtl/adc_host_pkg.sv
// Shared types for the serial converter host controller.
package adc_host_pkg;
    typedef enum logic [1:0] {
        PWR_UNKNOWN = 2'd0,
        PWR_NORMAL  = 2'd1,
        PWR_SHUT    = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        OP_CONVERT = 2'd0,
        OP_SLEEP   = 2'd1,
        OP_WAKE    = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FK_DUMMY = 2'd0,
        FK_CONV  = 2'd1,
        FK_SLEEP = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ACTIVE = 2'd1,
        SQ_QUIET  = 2'd2
    } seq_e;
endpackage

// File: rtl/adc_half_timer.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every DIV system clocks while run is high.
// Assumes DIV >= 1. The count restarts from zero whenever run drops.
module adc_half_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_direct
            // Every running cycle is a half-period boundary.
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            assign tick = run && (cnt == CW'(DIV - 1));

            // Count system clocks inside the current half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) cnt <= '0;
                else if (tick)      cnt <= '0;
                else                cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/adc_frame_seq.sv
// Frame sequencer: drives chip select and SCLK for one frame and then a quiet gap.
// A frame ends with chip select rising one half period after the rising
// edge that follows falling edge number stop_falls. The gap holds chip select
// high for 2*QUIET_CLKS-1 half periods. Assumes start is seen only while idle.
module adc_frame_seq #(
    parameter int DIV        = 4,
    parameter int FRAME_BITS = 16,
    parameter int QUIET_CLKS = 4,
    localparam int FW        = $clog2(FRAME_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] stop_falls,
    output logic          cs_n,
    output logic          sclk,
    output logic          sample,
    output logic          frame_end,
    output logic          idle
);
    import adc_host_pkg::*;

    localparam int QUIET_HALF = 2 * QUIET_CLKS - 1;
    localparam int QW         = $clog2(QUIET_HALF + 1);

    seq_e          state;
    logic [FW-1:0] falls;
    logic [FW-1:0] stop_q;
    logic [QW-1:0] qcnt;
    logic          tick;

    adc_half_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != SQ_IDLE),
        .tick (tick)
    );

    assign idle      = (state == SQ_IDLE);
    assign frame_end = tick && (state == SQ_ACTIVE) && sclk && (falls == stop_q);
    assign sample    = tick && (state == SQ_ACTIVE) && sclk && (falls != stop_q);

    // Step the frame one half period at a time and hold the quiet gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            cs_n   <= 1'b1;
            sclk   <= 1'b1;
            falls  <= '0;
            stop_q <= '0;
            qcnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state  <= SQ_ACTIVE;
                        cs_n   <= 1'b0;
                        sclk   <= 1'b1;
                        falls  <= '0;
                        stop_q <= stop_falls;
                    end
                end
                SQ_ACTIVE: begin
                    if (frame_end) begin
                        cs_n  <= 1'b1;
                        qcnt  <= '0;
                        state <= SQ_QUIET;
                    end else if (sample) begin
                        sclk  <= 1'b0;
                        falls <= falls + 1'b1;
                    end else if (tick) begin
                        sclk <= 1'b1;
                    end
                end
                SQ_QUIET: begin
                    if (tick) begin
                        if (qcnt == QW'(QUIET_HALF - 1)) state <= SQ_IDLE;
                        else                              qcnt  <= qcnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_rx_shift.sv
// Serial capture register. Shifts the data line in MSB first on every
// sample strobe. Only the last RES_W samples of a frame stay in the
// register, so leading bits fall off the top without extra logic.
module adc_rx_shift #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             sdata,
    output logic [RES_W-1:0] word
);
    // Shift one sampled bit per falling SCLK edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      word <= '0;
        else if (sample) word <= {word[RES_W-2:0], sdata};
    end
endmodule

// File: rtl/adc_sleep_host.sv
// Host controller for a 12-bit serial converter with power-down by short frame.
// Tracks the converter power state, inserts discarded dummy frames after
// reset and on wake, and turns a convert-while-asleep request into a dummy
// frame plus a conversion frame. Assumes 10 <= SLEEP_EDGE <= 14.
module adc_sleep_host #(
    parameter int DIV        = 4,
    parameter int RES_W      = 12,
    parameter int FRAME_BITS = 16,
    parameter int SLEEP_EDGE = 12,
    parameter int QUIET_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    output logic             cmd_ready,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    input  logic             adc_sdata,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic [1:0]       pwr_state,
    output logic             busy
);
    import adc_host_pkg::*;

    localparam int FW = $clog2(FRAME_BITS + 1);

    pwr_e             pwr;
    kind_e            kind;
    logic             init_pend;
    logic             chain;
    logic             seq_idle;
    logic             seq_start;
    logic             sample;
    logic             frame_end;
    logic             free;
    logic             take;
    logic             go_conv;
    logic             go_sleep;
    logic             go_wake;
    logic [FW-1:0]    stop_falls;
    logic [RES_W-1:0] word;

    assign free       = seq_idle && !init_pend && !chain;
    assign take       = cmd_valid && free;
    assign go_conv    = take && (cmd_op == OP_CONVERT);
    assign go_sleep   = take && (cmd_op == OP_SLEEP) && (pwr == PWR_NORMAL);
    assign go_wake    = take && (cmd_op == OP_WAKE) && (pwr == PWR_SHUT);
    assign seq_start  = seq_idle && (init_pend || chain || go_conv || go_sleep || go_wake);
    assign stop_falls = go_sleep ? FW'(SLEEP_EDGE) : FW'(FRAME_BITS);

    assign cmd_ready = free;
    assign busy      = !free;
    assign pwr_state = pwr;

    adc_frame_seq #(
        .DIV       (DIV),
        .FRAME_BITS(FRAME_BITS),
        .QUIET_CLKS(QUIET_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .stop_falls(stop_falls),
        .cs_n      (adc_cs_n),
        .sclk      (adc_sclk),
        .sample    (sample),
        .frame_end (frame_end),
        .idle      (seq_idle)
    );

    adc_rx_shift #(.RES_W(RES_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .sample(sample),
        .sdata (adc_sdata),
        .word  (word)
    );

    // Pick the kind of the frame being launched and keep pending-frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_pend <= 1'b1;
            chain     <= 1'b0;
            kind      <= FK_DUMMY;
        end else if (seq_idle) begin
            if (init_pend) begin
                init_pend <= 1'b0;
                kind      <= FK_DUMMY;
            end else if (chain) begin
                chain <= 1'b0;
                kind  <= FK_CONV;
            end else if (go_conv) begin
                if (pwr == PWR_SHUT) begin
                    kind  <= FK_DUMMY;
                    chain <= 1'b1;
                end else begin
                    kind <= FK_CONV;
                end
            end else if (go_sleep) begin
                kind <= FK_SLEEP;
            end else if (go_wake) begin
                kind <= FK_DUMMY;
            end
        end
    end

    // Update power tracking and the result at each chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr          <= PWR_UNKNOWN;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (frame_end) begin
                case (kind)
                    FK_DUMMY: pwr <= PWR_NORMAL;
                    FK_SLEEP: pwr <= PWR_SHUT;
                    FK_CONV: begin
                        result       <= word;
                        result_valid <= 1'b1;
                    end
                    default: pwr <= pwr;
                endcase
            end
        end
    end
endmodule

// File: rtl/adc_host_checker.sv
// Protocol checker for adc_sleep_host, attached by bind.
// Counts falling SCLK edges inside each chip-select-low window.
module adc_host_checker #(
    parameter int FRAME_BITS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_cs_n,
    input logic       adc_sclk,
    input logic       result_valid,
    input logic [1:0] pwr_state,
    input logic       busy
);
    logic       sclk_q;
    logic [7:0] nfall;

    // Track falling edges seen while chip select is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            nfall  <= '0;
        end else begin
            sclk_q <= adc_sclk;
            if (adc_cs_n)               nfall <= '0;
            else if (sclk_q && !adc_sclk) nfall <= nfall + 1'b1;
        end
    end

    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    // R3, R5: chip select rises after a full frame or inside the sleep window
    a_r5_cs_rise_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (nfall == 8'(FRAME_BITS) || (nfall >= 8'd10 && nfall <= 8'd14)));

    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r4_valid_when_normal: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (pwr_state == 2'd1));

    a_r1_no_unknown_return: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0) |=> (pwr_state != 2'd0));

    a_r10_frame_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy);
endmodule

bind adc_sleep_host adc_host_checker #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .result_valid(result_valid),
    .pwr_state   (pwr_state),
    .busy        (busy)
);

// File: tb/adc_sleep_host_tb.sv
module adc_sleep_host_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int SLEEP_EDGE = 11;
    localparam int QUIET_CLKS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_ready;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_sdata = 1'b0;
    logic [11:0] result;
    logic        result_valid;
    logic [1:0]  pwr_state;
    logic        busy;

    int tests = 0;
    int fails = 0;
    int valid_cnt = 0;

    // converter model state
    bit          in_frame = 0;
    bit          m_pow = 0;
    bit          m_frame_pow = 0;
    int          m_falls = 0;
    int          m_frame = 0;
    int          last_falls = 0;
    logic [15:0] m_word = '0;
    logic [11:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_sleep_host #(
        .DIV(DIV), .RES_W(12), .FRAME_BITS(16),
        .SLEEP_EDGE(SLEEP_EDGE), .QUIET_CLKS(QUIET_CLKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_sdata(adc_sdata), .result(result), .result_valid(result_valid),
        .pwr_state(pwr_state), .busy(busy)
    );

    function automatic logic [11:0] pat(int f);
        return 12'(f * 12'h2B7) ^ 12'hA53;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model: frame start
    always @(negedge adc_cs_n) begin
        in_frame    = 1;
        m_falls     = 0;
        m_frame_pow = m_pow;
        m_word      = m_pow ? {4'b0, pat(m_frame)} : 16'hFFFF;
        adc_sdata   = m_word[15];
    end

    // Converter model: next bit after each falling edge
    always @(negedge adc_sclk) begin
        if (in_frame) begin
            m_falls++;
            adc_sdata = (m_falls < 16) ? m_word[15 - m_falls] : 1'b0;
        end
    end

    // Converter model: power state from where chip select rose
    always @(posedge adc_cs_n) begin
        if (in_frame) begin
            in_frame   = 0;
            last_falls = m_falls;
            if (m_falls >= 16) begin
                if (m_frame_pow) exp_q.push_back(pat(m_frame));
                m_pow = 1;
            end else begin
                m_pow = 0;
            end
            m_frame++;
        end
    end

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_cs_n && !adc_sclk) begin
                fails++;
                $display("FAIL R2 sclk low while idle: actual 0 expected 1");
            end
            if (result_valid) begin
                valid_cnt++;
                if (exp_q.size() == 0) chk("R4", "unexpected valid", 1, 0);
                else chk("R3", "result value", int'(result), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic send(logic [1:0] op);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_wait(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        time t1;
        int  v0;
        int  f0;
        idle_wait(4);
        chk("R1", "reset cs_n", int'(adc_cs_n), 1);
        chk("R1", "reset sclk", int'(adc_sclk), 1);
        chk("R1", "reset pwr_state", int'(pwr_state), 0);
        chk("R1", "reset result_valid", int'(result_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 1);
        wait_idle();
        chk("R1", "pwr normal after dummy", int'(pwr_state), 1);
        chk("R1", "no valid from dummy", valid_cnt, 0);
        chk("R1", "dummy frame edges", last_falls, 16);

        // R2 half period, R3/R4 normal conversion
        send(2'b00);
        @(negedge adc_sclk);
        t1 = $time;
        @(posedge adc_sclk);
        chk("R2", "sclk half period", int'(($time - t1) / CLK_PERIOD), DIV);
        wait_idle();
        chk("R4", "one valid per convert", valid_cnt, 1);
        chk("R3", "conversion frame edges", last_falls, 16);

        // R10: commands held while busy are not taken
        send(2'b00);
        chk("R10", "ready low while busy", int'(cmd_ready), 0);
        cmd_valid = 1'b1;
        cmd_op    = 2'b01;
        idle_wait(20);
        cmd_valid = 1'b0;
        wait_idle();
        chk("R10", "held sleep ignored", int'(pwr_state), 1);
        chk("R10", "held sleep frame edges", last_falls, 16);
        send(2'b00);
        wait_idle();
        chk("R4", "valid count after three", valid_cnt, 3);

        // R5 sleep
        v0 = valid_cnt;
        send(2'b01);
        wait_idle();
        chk("R5", "pwr shutdown", int'(pwr_state), 2);
        chk("R5", "sleep rise edge", last_falls, SLEEP_EDGE);
        chk("R5", "no valid from sleep", valid_cnt, v0);

        // R9 sleep in shutdown ignored
        f0 = m_frame;
        send(2'b01);
        idle_wait(60);
        chk("R9", "sleep in shutdown no frame", m_frame, f0);
        chk("R9", "sleep in shutdown state", int'(pwr_state), 2);

        // R6 wake
        send(2'b10);
        wait_idle();
        chk("R6", "pwr after wake", int'(pwr_state), 1);
        chk("R6", "wake frame edges", last_falls, 16);
        chk("R6", "no valid from wake", valid_cnt, v0);

        // R9 wake in normal and no-op ignored
        f0 = m_frame;
        send(2'b10);
        send(2'b11);
        idle_wait(60);
        chk("R9", "wake/no-op no frame", m_frame, f0);
        chk("R9", "wake/no-op state", int'(pwr_state), 1);

        send(2'b00);
        wait_idle();
        chk("R4", "convert after wake", valid_cnt, v0 + 1);

        // R7 convert while asleep, R8 quiet gap
        send(2'b01);
        wait_idle();
        chk("R7", "asleep before convert", int'(pwr_state), 2);
        v0 = valid_cnt;
        f0 = m_frame;
        send(2'b00);
        @(posedge adc_cs_n);
        t1 = $time;
        @(negedge adc_cs_n);
        chk("R8", "quiet gap long enough",
            int'(($time - t1) / CLK_PERIOD) >= (2 * QUIET_CLKS - 1) * DIV, 1);
        wait_idle();
        chk("R7", "two frames", m_frame, f0 + 2);
        chk("R7", "exactly one valid", valid_cnt, v0 + 1);
        chk("R7", "pwr normal", int'(pwr_state), 1);
        chk("R4", "no pending results", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule